// File: doc/BRIEF.md
# System Clock Source Selector

This block picks the source of the core clock from a two-bit mode value that comes from an initialization register. Three sources are possible: the on-chip oscillator, an external square-wave input, and an external crystal or resonator. The on-chip oscillator is halved before it reaches the core, so a 2 MHz oscillator gives a 1 MHz core clock. An external square wave, which may run anywhere from DC up to 4 MHz, is passed through at its own rate. In crystal mode the block also enables the oscillator drive on a second pin, and the first pin serves as the clock input. The code 11 is reserved. It behaves like the internal mode, so the core always has a clock.

The block works synchronously on a fast reference clock. Both raw sources pass through synchronizers. The core clock is built as a registered waveform. A halt request gates the core clock off without a glitch. The gate closes only while the selected source is low. It reopens only when the halt is gone and the source is low again. While the core is halted in internal mode, the oscillator enable drops so the oscillator can stop.

Top module: `clk_source_sel`

## Requirements
- R1: While rstN is low, coreClk is 0 and the gate is open. The pin enables then follow the mode decode alone.
- R2: In modes 00 and 11, coreClk toggles once for every rising edge of oscIn, so it has half the oscillator's frequency. Each rising edge of oscIn reaches coreClk SYNC_STAGES+2 reference cycles later.
- R3: In mode 01, coreClk repeats extIn undivided, SYNC_STAGES+1 reference cycles later.
- R4: In mode 10, coreClk repeats extIn in the same way as mode 01. In this mode xtalDrvEn is 1; in every other mode it is 0.
- R5: Mode 11 gives the same coreClk behaviour as mode 00, and it drives extInEn and xtalDrvEn to 0.
- R6: While haltReq is 1, the gate closes in the first cycle in which the selected source is low. From then on coreClk stays 0. A high pulse that has already started is never cut short.
- R7: After haltReq drops, the gate opens in the first cycle in which the selected source is low. coreClk is 0 in that cycle, so the first pulse after wake-up is a complete one.
- R8: oscEn is 1 exactly when the mode is 00 or 11 and the block is not in the halted state with its gate closed.
- R9: extInEn is 1 exactly in modes 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock that samples both sources |
| rstN | input | 1 | Asynchronous reset, active low |
| clkMode | input | 2 | Source select: 00 internal, 01 square, 10 crystal, 11 reserved (treated as internal) |
| haltReq | input | 1 | Request to stop the core clock |
| oscIn | input | 1 | Raw on-chip oscillator waveform |
| extIn | input | 1 | Raw external clock waveform |
| coreClk | output | 1 | Gated core clock waveform |
| oscEn | output | 1 | Run enable for the on-chip oscillator |
| extInEn | output | 1 | Enables the pin as the external clock input |
| xtalDrvEn | output | 1 | Enables the crystal drive output on the second pin |

## Verification
Most faults in this block show up on coreClk within a few reference cycles. A divider that is stuck or toggles twice changes the period of coreClk at its next oscillator edge. A wrong synchronizer depth moves every edge by one cycle. A gate state left open during halt lets the next source high pass through, and a gate state left closed after wake-up keeps coreClk low. Each of these shows within one source half-period. Decode faults appear at once on the pin enables in the cycle the mode changes. The bench therefore compares all four outputs against its reference model on every reference cycle.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_INT  = 2'b00,
    MODE_SQR  = 2'b01,
    MODE_XTAL = 2'b10,
    MODE_RSVD = 2'b11
  } clkMode_e;

  typedef struct packed {
    logic useDiv;
    logic divEn;
    logic gateOpen;
  } clkStrb_t;
endpackage

// File: rtl/clksel_dp.sv
module clksel_dp
  import clksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     oscIn,
  input  logic     extIn,
  input  clkStrb_t strb,
  output logic     srcLevel,
  output logic     coreClk
);
  localparam int NUM_SRC = 2;
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] rawIn;
  logic [NUM_SRC-1:0][SYNC_STAGES-1:0] shReg;
  logic oscPrev;
  logic oscRise;
  logic divQ;

  assign rawIn = {extIn, oscIn};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shReg[g] <= '0;
        else       shReg[g] <= rawIn[g];
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shReg[g] <= '0;
        else       shReg[g] <= {shReg[g][SYNC_STAGES-2:0], rawIn[g]};
      end
    end
  end

  assign oscRise = shReg[0][LAST] & ~oscPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscPrev <= 1'b0;
      divQ    <= 1'b0;
    end else begin
      oscPrev <= shReg[0][LAST];
      if (strb.divEn && oscRise) divQ <= ~divQ;
    end
  end

  assign srcLevel = strb.useDiv ? divQ : shReg[1][LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) coreClk <= 1'b0;
    else       coreClk <= strb.gateOpen ? srcLevel : 1'b0;
  end

  // divider advances at most once per synchronized oscillator rise (R2)
  p_div_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (divQ != $past(divQ)) |-> $past(oscRise && strb.divEn));
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
  import clksel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] clkMode,
  input  logic              haltReq,
  input  logic              srcLevel,
  input  logic              coreClk,
  output clkStrb_t          strb,
  output logic              oscEn,
  output logic              extInEn,
  output logic              xtalDrvEn
);
  clkMode_e modeSel;
  logic internalSel;
  logic gateOpen;

  assign modeSel     = clkMode_e'(clkMode);
  assign internalSel = (modeSel == MODE_INT) || (modeSel == MODE_RSVD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateOpen <= 1'b1;
    end else if (gateOpen) begin
      if (haltReq && !srcLevel) gateOpen <= 1'b0;
    end else begin
      if (!haltReq && !srcLevel) gateOpen <= 1'b1;
    end
  end

  always_comb begin
    strb.useDiv   = internalSel;
    strb.divEn    = gateOpen || !haltReq;
    strb.gateOpen = gateOpen;
  end

  assign oscEn     = internalSel && (gateOpen || !haltReq);
  assign extInEn   = (modeSel == MODE_SQR) || (modeSel == MODE_XTAL);
  assign xtalDrvEn = (modeSel == MODE_XTAL);

  // crystal drive never without the clock input pin (R4)
  p_xtal_needs_in_r4: assert property (@(posedge clk) disable iff (!rstN)
    xtalDrvEn |-> extInEn);

  // oscillator never enabled while an external source is chosen (R8)
  p_osc_off_ext_r8: assert property (@(posedge clk) disable iff (!rstN)
    extInEn |-> !oscEn);

  // core clock frozen while halted with gate shut (R6)
  p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOpen && haltReq) |=> $stable(coreClk));

  // wake-up starts from a low core clock (R7)
  p_wake_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOpen) |-> !coreClk);
endmodule

// File: rtl/clk_source_sel.sv
module clk_source_sel
  import clksel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] clkMode,
  input  logic       haltReq,
  input  logic       oscIn,
  input  logic       extIn,
  output logic       coreClk,
  output logic       oscEn,
  output logic       extInEn,
  output logic       xtalDrvEn
);
  clkStrb_t strb;
  logic srcLevel;

  clksel_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clkMode   (clkMode),
    .haltReq   (haltReq),
    .srcLevel  (srcLevel),
    .coreClk   (coreClk),
    .strb      (strb),
    .oscEn     (oscEn),
    .extInEn   (extInEn),
    .xtalDrvEn (xtalDrvEn)
  );

  clksel_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .oscIn    (oscIn),
    .extIn    (extIn),
    .strb     (strb),
    .srcLevel (srcLevel),
    .coreClk  (coreClk)
  );

  // reset leaves the core clock low (R1)
  p_reset_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !coreClk);
endmodule

// File: tb/clk_source_sel_tb.sv
`timescale 1ns/1ps
module clk_source_sel_tb;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] clkMode = 2'b00;
  logic haltReq = 1'b0;
  logic oscIn = 1'b0;
  logic extIn = 1'b0;
  logic coreClk, oscEn, extInEn, xtalDrvEn;

  int checks = 0;
  int errors = 0;
  int extHalf = 3;
  bit finished = 0;
  string curTag = "R1";

  always #10 clk = ~clk;

  clk_source_sel #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rstN(rstN), .clkMode(clkMode), .haltReq(haltReq),
    .oscIn(oscIn), .extIn(extIn), .coreClk(coreClk), .oscEn(oscEn),
    .extInEn(extInEn), .xtalDrvEn(xtalDrvEn)
  );

  // behavioural reference
  bit oscQ[$];
  bit extQ[$];
  bit mPrev, mDiv, mCore, mGate;

  function automatic bit isInternal(input logic [1:0] m);
    return (m == 2'b00) || (m == 2'b11);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscQ = {};
      extQ = {};
      for (int i = 0; i < SYNC; i++) begin
        oscQ.push_back(1'b0);
        extQ.push_back(1'b0);
      end
      mPrev = 0; mDiv = 0; mCore = 0; mGate = 1;
    end else begin
      bit oscS, rise, src, divEn;
      oscS  = oscQ[0];
      rise  = oscS && !mPrev;
      src   = isInternal(clkMode) ? mDiv : extQ[0];
      divEn = mGate || !haltReq;
      mCore = mGate ? src : 1'b0;
      if (mGate) mGate = !(haltReq && !src);
      else       mGate = !haltReq && !src;
      if (divEn && rise) mDiv = !mDiv;
      mPrev = oscS;
      void'(oscQ.pop_front());
      oscQ.push_back(oscIn);
      void'(extQ.pop_front());
      extQ.push_back(extIn);
    end
  end

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  initial begin
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (finished) break;
      checkBit(curTag, "coreClk", coreClk, mCore);
      checkBit("R8", "oscEn", oscEn, isInternal(clkMode) && (mGate || !haltReq));
      checkBit("R9", "extInEn", extInEn, clkMode == 2'b01 || clkMode == 2'b10);
      checkBit("R4", "xtalDrvEn", xtalDrvEn, clkMode == 2'b10);
    end
  end

  // source generators
  initial forever begin
    repeat (3) @(negedge clk);
    #1 oscIn = ~oscIn;
  end

  initial forever begin
    repeat (extHalf) @(negedge clk);
    #1 extIn = ~extIn;
  end

  task automatic countRises(input int cycles, output int n);
    logic prev;
    n = 0;
    prev = coreClk;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (coreClk && !prev) n++;
      prev = coreClk;
    end
  endtask

  task automatic setInputs(input logic [1:0] m, input logic h, input string tag);
    @(negedge clk);
    #1;
    clkMode = m;
    haltReq = h;
    curTag = tag;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1: reset state
    checkBit("R1", "coreClk in reset", coreClk, 1'b0);
    checkBit("R1", "oscEn in reset", oscEn, 1'b1);
    checkBit("R1", "extInEn in reset", extInEn, 1'b0);
    checkBit("R1", "xtalDrvEn in reset", xtalDrvEn, 1'b0);
    #1 rstN = 1'b1;

    // R2: internal divided clock, period 12 reference cycles
    setInputs(2'b00, 1'b0, "R2");
    repeat (20) @(negedge clk);
    countRises(240, n);
    checks++;
    if (n < 19 || n > 21) begin
      errors++;
      $display("FAIL R2 rise count: actual %0d expected 20", n);
    end

    // R3: square external clock, two rates
    extHalf = 4;
    setInputs(2'b01, 1'b0, "R3");
    repeat (20) @(negedge clk);
    countRises(240, n);
    checks++;
    if (n < 29 || n > 31) begin
      errors++;
      $display("FAIL R3 rise count: actual %0d expected 30", n);
    end
    extHalf = 1;
    repeat (60) @(negedge clk);

    // R4: crystal mode
    extHalf = 5;
    setInputs(2'b10, 1'b0, "R4");
    repeat (150) @(negedge clk);

    // R5: reserved code acts as internal
    setInputs(2'b11, 1'b0, "R5");
    repeat (20) @(negedge clk);
    countRises(240, n);
    checks++;
    if (n < 19 || n > 21) begin
      errors++;
      $display("FAIL R5 rise count: actual %0d expected 20", n);
    end

    // R6 / R7: halts of several lengths and phases, internal mode
    for (int k = 0; k < 6; k++) begin
      setInputs(2'b00, 1'b1, "R6");
      repeat (40 + 7 * k) @(negedge clk);
      countRises(60, n);
      checks++;
      if (n != 0) begin
        errors++;
        $display("FAIL R6 rises while halted: actual %0d expected 0", n);
      end
      setInputs(2'b00, 1'b0, "R7");
      repeat (30 + 5 * k) @(negedge clk);
    end

    // R6 / R7: halt with square external source
    extHalf = 3;
    for (int k = 0; k < 4; k++) begin
      setInputs(2'b01, 1'b1, "R6");
      repeat (25 + 3 * k) @(negedge clk);
      setInputs(2'b01, 1'b0, "R7");
      repeat (20 + 4 * k) @(negedge clk);
    end

    // mode switching while running
    for (int k = 0; k < 8; k++) begin
      setInputs(2'(k % 4), 1'b0, "R2");
      repeat (17) @(negedge clk);
    end

    finished = 1;
    @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule